// File: doc/BRIEF.md
# Detect Output Qualifier with Programmable Delays

This block turns a raw level-detector indication (received energy above threshold) into a debounced, active-low detect output. The output asserts only after the raw input has held its new state for a programmed number of 1 ms ticks. It releases only after the raw input has held the opposite state for a separate, usually shorter, count. A 2-bit timing code selects one of four on/off pairs in FSK mode. Call-progress mode uses a fixed pair of its own.

While no detection is qualified, the received-data output is clamped high, so line noise cannot reach the data path. Power-down drives the detect output low and clears the qualifier. The remaining mode forces the detect output high. The block is clocked by the system clock and takes a single-cycle 1 ms tick strobe from a shared timebase.

Top module: `dq_detect_top`

## Requirements
- R1: During and after synchronous reset the qualifier is in the no-detect state: in FSK mode (mode = 2'b01) `det_n` is 1 and `rxd_out` is 1.
- R2: In FSK mode, `det_n` falls on the clock edge of the N-th consecutive tick with `raw_det` = 1, where N is 450, 15, 15 or 80 for `tcode` = 2'b00, 2'b01, 2'b10 or 2'b11.
- R3: In FSK mode, a qualified detection is released (`det_n` rises) on the edge of the M-th consecutive tick with `raw_det` = 0, where M is 30, 30, 15 or 10 for `tcode` = 2'b00, 2'b01, 2'b10 or 2'b11.
- R4: In call-progress mode (mode = 2'b10) the turn-on count is 10 ticks and the turn-off count is 25 ticks, whatever the value of `tcode`.
- R5: Any clock cycle in which `raw_det` equals the current qualified state restarts the pending count from zero.
- R6: Only cycles with `tick_1ms` = 1 advance a count. Cycles without a tick neither advance nor clear it.
- R7: In FSK or call-progress mode, `rxd_out` equals `raw_rxd` while `det_n` is 0. Whenever `det_n` is 1, `rxd_out` is 1.
- R8: In the auxiliary mode (mode = 2'b11) `det_n` and `rxd_out` are 1, and the qualifier is held in the no-detect state.
- R9: In power-down (mode = 2'b00) `det_n` is 0 and `rxd_out` is 1. The qualifier is held in the no-detect state, so a later turn-on needs the full count.
- R10: A change of `mode` or `tcode` clears the pending count on the next clock edge, so the new turn-on count starts afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle strobe every millisecond |
| raw_det | input | 1 | Unfiltered level detector, 1 = energy above threshold |
| raw_rxd | input | 1 | Unqualified demodulated data |
| mode | input | 2 | 00 power-down, 01 FSK, 10 call-progress, 11 auxiliary |
| tcode | input | 2 | FSK timing-set select |
| det_n | output | 1 | Qualified detect, active low |
| rxd_out | output | 1 | Received data, clamped high when not detected |

## Verification
Each of the five timing configurations (four FSK codes and call-progress) is swept from a cleared state with a steady raw level. The output is checked one tick before and exactly at the expected count in both directions, which separates the on and off tables and off-by-one edges. A one-tick dropout just before the turn-on count shows whether the count restarts or only pauses. Long stretches without ticks show that idle cycles neither count nor clear. A code change after 400 ticks of a 450-tick wait separates a cleared counter from a carried-over one. Mode excursions through power-down and auxiliary show the forced outputs and that the qualifier comes back in the no-detect state.

// File: rtl/dq_pkg.sv
// Package: shared mode encoding and helpers for the detect qualifier.
// Assumes a 2-bit mode field decoded identically by every sub-block.
package dq_pkg;

    typedef enum logic [1:0] {
        MODE_PDN = 2'b00,
        MODE_FSK = 2'b01,
        MODE_CPT = 2'b10,
        MODE_AUX = 2'b11
    } dq_mode_e;

    // Larger of two integers, used to size counters from parameters.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dq_cfg_watch.sv
// Module: dq_cfg_watch
// Registers the mode and timing code and flags any cycle in which either
// differs from the previous cycle's value. Assumes inputs are synchronous.
module dq_cfg_watch
    import dq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic [1:0] tcode,
    output logic       cfg_chg
);

    logic [1:0] mode_q;
    logic [1:0] code_q;

    // Keep last cycle's configuration for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PDN;
            code_q <= 2'b00;
        end else begin
            mode_q <= mode;
            code_q <= tcode;
        end
    end

    // Flag a change in either configuration field.
    always_comb begin
        cfg_chg = (mode != mode_q) || (tcode != code_q);
    end

endmodule

// File: rtl/dq_limit_sel.sv
// Module: dq_limit_sel
// Picks the tick limit for the pending transition from the mode, the
// timing code and the current qualified state. Assumes every limit >= 1.
module dq_limit_sel
    import dq_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int ON_T0   = 450,
    parameter int ON_T1   = 15,
    parameter int ON_T2   = 15,
    parameter int ON_T3   = 80,
    parameter int OFF_T0  = 30,
    parameter int OFF_T1  = 30,
    parameter int OFF_T2  = 15,
    parameter int OFF_T3  = 10,
    parameter int CPT_ON  = 10,
    parameter int CPT_OFF = 25
) (
    input  logic [1:0]       mode,
    input  logic [1:0]       tcode,
    input  logic             det_q,
    output logic [CNT_W-1:0] lim_sel
);

    localparam int NSET = 4;
    localparam logic [CNT_W-1:0] L_CPT_ON  = CNT_W'(CPT_ON);
    localparam logic [CNT_W-1:0] L_CPT_OFF = CNT_W'(CPT_OFF);

    logic [CNT_W-1:0] on_tab  [NSET];
    logic [CNT_W-1:0] off_tab [NSET];
    logic [CNT_W-1:0] fsk_on;
    logic [CNT_W-1:0] fsk_off;

    // Build the per-code limit tables from parameters.
    generate
        for (genvar g = 0; g < NSET; g++) begin : g_tab
            localparam int ON_V  = (g == 0) ? ON_T0  : (g == 1) ? ON_T1  :
                                   (g == 2) ? ON_T2  : ON_T3;
            localparam int OFF_V = (g == 0) ? OFF_T0 : (g == 1) ? OFF_T1 :
                                   (g == 2) ? OFF_T2 : OFF_T3;
            assign on_tab[g]  = CNT_W'(ON_V);
            assign off_tab[g] = CNT_W'(OFF_V);
        end
    endgenerate

    // Look up the FSK pair chosen by the timing code.
    always_comb begin
        fsk_on  = on_tab[tcode];
        fsk_off = off_tab[tcode];
    end

    // Choose the limit for the transition that is currently pending.
    always_comb begin
        if (mode == MODE_CPT) begin
            lim_sel = det_q ? L_CPT_OFF : L_CPT_ON;
        end else begin
            lim_sel = det_q ? fsk_off : fsk_on;
        end
    end

endmodule

// File: rtl/dq_qualifier.sv
// Module: dq_qualifier
// Tick-counting debouncer. Counts consecutive ticks with the raw input
// opposite to the qualified state and flips the state at the limit.
// Assumes lim_sel >= 1 and stable for the cycle it is used.
module dq_qualifier #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw,
    input  logic             hold,
    input  logic             cnt_clr,
    input  logic [CNT_W-1:0] lim_sel,
    output logic             det_q,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W:0] cnt_nxt;
    logic           at_lim;

    // Next count and limit comparison, one bit wider to avoid wrap.
    always_comb begin
        cnt_nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        at_lim  = (cnt_nxt >= {1'b0, lim_sel});
    end

    // Qualified state and pending count.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            det_q <= 1'b0;
            cnt   <= '0;
        end else if (cnt_clr || (raw == det_q)) begin
            cnt   <= '0;
        end else if (tick) begin
            if (at_lim) begin
                det_q <= ~det_q;
                cnt   <= '0;
            end else begin
                cnt   <= cnt_nxt[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dq_out_drive.sv
// Module: dq_out_drive
// Forms the active-low detect output and the clamped data output from
// the mode and the qualified state. Purely combinational.
module dq_out_drive
    import dq_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       det_q,
    input  logic       raw_rxd,
    output logic       det_n,
    output logic       rxd_out
);

    logic active;

    // Detect output per mode; data passes only while detected.
    always_comb begin
        active = (mode == MODE_FSK) || (mode == MODE_CPT);
        unique case (mode)
            MODE_PDN: det_n = 1'b0;
            MODE_FSK,
            MODE_CPT: det_n = ~det_q;
            default:  det_n = 1'b1;
        endcase
        rxd_out = (active && det_q) ? raw_rxd : 1'b1;
    end

endmodule

// File: rtl/dq_detect_top.sv
// Module: dq_detect_top
// Detect output qualifier with programmable turn-on/turn-off delays.
// Assumes tick_1ms is a synchronous single-cycle strobe and raw inputs
// are already synchronised to clk.
module dq_detect_top
    import dq_pkg::*;
#(
    parameter int ON_T0   = 450,
    parameter int ON_T1   = 15,
    parameter int ON_T2   = 15,
    parameter int ON_T3   = 80,
    parameter int OFF_T0  = 30,
    parameter int OFF_T1  = 30,
    parameter int OFF_T2  = 15,
    parameter int OFF_T3  = 10,
    parameter int CPT_ON  = 10,
    parameter int CPT_OFF = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       raw_det,
    input  logic       raw_rxd,
    input  logic [1:0] mode,
    input  logic [1:0] tcode,
    output logic       det_n,
    output logic       rxd_out
);

    localparam int MAX_ON  = imax(imax(ON_T0, ON_T1), imax(imax(ON_T2, ON_T3), CPT_ON));
    localparam int MAX_OFF = imax(imax(OFF_T0, OFF_T1), imax(imax(OFF_T2, OFF_T3), CPT_OFF));
    localparam int MAX_T   = imax(MAX_ON, MAX_OFF);
    localparam int CNT_W   = $clog2(MAX_T + 1);

    logic             cfg_chg;
    logic             q_hold;
    logic             det_q;
    logic [CNT_W-1:0] q_cnt;
    logic [CNT_W-1:0] lim_sel;

    // Qualifier is held cleared outside the two detecting modes.
    always_comb begin
        q_hold = (mode == MODE_PDN) || (mode == MODE_AUX);
    end

    dq_cfg_watch u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .tcode   (tcode),
        .cfg_chg (cfg_chg)
    );

    dq_limit_sel #(
        .CNT_W   (CNT_W),
        .ON_T0   (ON_T0),
        .ON_T1   (ON_T1),
        .ON_T2   (ON_T2),
        .ON_T3   (ON_T3),
        .OFF_T0  (OFF_T0),
        .OFF_T1  (OFF_T1),
        .OFF_T2  (OFF_T2),
        .OFF_T3  (OFF_T3),
        .CPT_ON  (CPT_ON),
        .CPT_OFF (CPT_OFF)
    ) u_lim (
        .mode    (mode),
        .tcode   (tcode),
        .det_q   (det_q),
        .lim_sel (lim_sel)
    );

    dq_qualifier #(
        .CNT_W (CNT_W)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1ms),
        .raw     (raw_det),
        .hold    (q_hold),
        .cnt_clr (cfg_chg),
        .lim_sel (lim_sel),
        .det_q   (det_q),
        .cnt     (q_cnt)
    );

    dq_out_drive u_out (
        .mode    (mode),
        .det_q   (det_q),
        .raw_rxd (raw_rxd),
        .det_n   (det_n),
        .rxd_out (rxd_out)
    );

endmodule

// File: rtl/dq_detect_chk.sv
// Module: dq_detect_chk
// Property checker for dq_detect_top, attached by bind below.
module dq_detect_chk
    import dq_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1ms,
    input  logic             raw_det,
    input  logic             raw_rxd,
    input  logic [1:0]       mode,
    input  logic             det_n,
    input  logic             rxd_out,
    input  logic             det_q,
    input  logic [CNT_W-1:0] q_cnt,
    input  logic [CNT_W-1:0] lim_sel,
    input  logic             cfg_chg,
    input  logic             q_hold
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!det_q && q_cnt == '0)); // R1

    AST_PDN_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PDN) |-> (!det_n && rxd_out)); // R9

    AST_AUX_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AUX) |-> (det_n && rxd_out)); // R8

    AST_RXD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        det_n |-> rxd_out); // R7

    AST_RXD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_n && (mode == MODE_FSK || mode == MODE_CPT)) |-> (rxd_out == raw_rxd)); // R7

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1ms && !cfg_chg && !q_hold) |=> $stable(det_q)); // R6

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_det == det_q) |=> (q_cnt == '0)); // R5

    AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (q_cnt == '0)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |-> (q_cnt < lim_sel)); // R2

endmodule

bind dq_detect_top dq_detect_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1ms (tick_1ms),
    .raw_det  (raw_det),
    .raw_rxd  (raw_rxd),
    .mode     (mode),
    .det_n    (det_n),
    .rxd_out  (rxd_out),
    .det_q    (det_q),
    .q_cnt    (q_cnt),
    .lim_sel  (lim_sel),
    .cfg_chg  (cfg_chg),
    .q_hold   (q_hold)
);

// File: tb/tb_dq_detect_top.sv
module tb_dq_detect_top;

    localparam int CLK_P  = 10;
    localparam int WD_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_1ms;
    logic       raw_det;
    logic       raw_rxd;
    logic [1:0] mode;
    logic [1:0] tcode;
    logic       det_n;
    logic       rxd_out;

    int total = 0;
    int bad   = 0;

    dq_detect_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1ms (tick_1ms),
        .raw_det  (raw_det),
        .raw_rxd  (raw_rxd),
        .mode     (mode),
        .tcode    (tcode),
        .det_n    (det_n),
        .rxd_out  (rxd_out)
    );

    always #(CLK_P/2) clk = ~clk;

    // Turn-on count from the requirements (R2, R4).
    function automatic int exp_on(input logic [1:0] m, input logic [1:0] c);
        if (m == 2'b10) return 10;
        case (c)
            2'b00:   return 450;
            2'b01:   return 15;
            2'b10:   return 15;
            default: return 80;
        endcase
    endfunction

    // Turn-off count from the requirements (R3, R4).
    function automatic int exp_off(input logic [1:0] m, input logic [1:0] c);
        if (m == 2'b10) return 25;
        case (c)
            2'b00:   return 30;
            2'b01:   return 30;
            2'b10:   return 15;
            default: return 10;
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // n cycles with tick held at tk; starts and ends at a falling edge.
    task automatic run(input int n, input logic tk);
        for (int i = 0; i < n; i++) begin
            tick_1ms = tk;
            @(negedge clk);
        end
        tick_1ms = 1'b0;
    endtask

    // Clear the qualifier through power-down, then apply a configuration.
    task automatic setup(input logic [1:0] m, input logic [1:0] c);
        raw_det = 1'b0;
        mode    = 2'b00;
        run(1, 1'b0);
        mode  = m;
        tcode = c;
        run(2, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; tick_1ms = 1'b0; raw_det = 1'b1; raw_rxd = 1'b0;
        mode = 2'b01; tcode = 2'b01;
        run(3, 1'b1);
        chk("R1 det_n in reset", det_n, 1'b1);
        rst_n = 1'b1;
        raw_det = 1'b0;
        run(2, 1'b0);
        chk("R1 det_n after reset", det_n, 1'b1);
        chk("R1 rxd_out after reset", rxd_out, 1'b1);

        // Sweep four FSK codes and call-progress mode.
        for (int k = 0; k < 5; k++) begin
            logic [1:0] m;
            logic [1:0] c;
            int lon;
            int loff;
            m = (k < 4) ? 2'b01 : 2'b10;
            c = (k < 4) ? 2'(k) : 2'b11;
            lon  = exp_on(m, c);
            loff = exp_off(m, c);
            setup(m, c);
            raw_det = 1'b1;
            run(lon - 1, 1'b1);
            chk((k < 4) ? "R2 on-1 still high" : "R4 on-1 still high", det_n, 1'b1);
            raw_det = 1'b0;
            run(1, 1'b1);
            raw_det = 1'b1;
            run(lon - 1, 1'b1);
            chk("R5 dropout restarts on count", det_n, 1'b1);
            run(1, 1'b1);
            chk((k < 4) ? "R2 on at count" : "R4 on at count", det_n, 1'b0);
            raw_rxd = 1'b0;
            run(1, 1'b0);
            chk("R7 rxd follows 0", rxd_out, 1'b0);
            raw_rxd = 1'b1;
            run(1, 1'b0);
            chk("R7 rxd follows 1", rxd_out, 1'b1);
            raw_det = 1'b0;
            run(loff - 1, 1'b1);
            chk((k < 4) ? "R3 off-1 still low" : "R4 off-1 still low", det_n, 1'b0);
            raw_det = 1'b1;
            run(1, 1'b1);
            raw_det = 1'b0;
            run(loff - 1, 1'b1);
            chk("R5 dropout restarts off count", det_n, 1'b0);
            run(1, 1'b1);
            chk((k < 4) ? "R3 off at count" : "R4 off at count", det_n, 1'b1);
            raw_rxd = 1'b0;
            run(1, 1'b0);
            chk("R7 rxd clamped high", rxd_out, 1'b1);
        end

        // R6: cycles without a tick neither count nor clear.
        setup(2'b01, 2'b01);
        raw_det = 1'b1;
        run(7, 1'b1);
        run(500, 1'b0);
        chk("R6 no tick no count", det_n, 1'b1);
        run(7, 1'b1);
        chk("R6 idle kept count", det_n, 1'b1);
        run(1, 1'b1);
        chk("R6 count resumes to 15", det_n, 1'b0);

        // R10: code change clears the pending count.
        setup(2'b01, 2'b00);
        raw_det = 1'b1;
        run(400, 1'b1);
        tcode = 2'b11;
        run(1, 1'b0);
        run(79, 1'b1);
        chk("R10 count cleared on code change", det_n, 1'b1);
        run(1, 1'b1);
        chk("R10 new count of 80", det_n, 1'b0);

        // R8: auxiliary mode forces outputs high and clears the state.
        raw_rxd = 1'b0;
        mode = 2'b11;
        run(1, 1'b0);
        chk("R8 det_n forced high", det_n, 1'b1);
        chk("R8 rxd_out forced high", rxd_out, 1'b1);
        run(100, 1'b1);
        chk("R8 still high under ticks", det_n, 1'b1);
        mode = 2'b01;
        run(1, 1'b0);
        chk("R8 returns in no-detect", det_n, 1'b1);
        run(79, 1'b1);
        chk("R8 full turn-on needed", det_n, 1'b1);
        run(1, 1'b1);
        chk("R8 turn-on after 80", det_n, 1'b0);

        // R9: power-down drives detect low and clears the state.
        mode = 2'b00;
        run(1, 1'b0);
        chk("R9 det_n low", det_n, 1'b0);
        chk("R9 rxd_out high", rxd_out, 1'b1);
        run(100, 1'b1);
        chk("R9 stays low", det_n, 1'b0);
        mode = 2'b01;
        tcode = 2'b10;
        run(1, 1'b0);
        chk("R9 returns in no-detect", det_n, 1'b1);
        run(14, 1'b1);
        chk("R9 full turn-on needed", det_n, 1'b1);
        run(1, 1'b1);
        chk("R9 turn-on after 15", det_n, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * WD_CYC);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule